// File: doc/BRIEF.md
# Configuration Download Front End

This block sits between the configuration pins of a programmable device and the writer that fills its configuration memory. It accepts a bitstream over one of five transfer modes, chosen by a three-bit mode input: three serial modes (0, 1, 7) in which one data line carries the stream, a parallel peripheral mode (2) in which an external host presents bytes, and a parallel master mode (6) in which the block itself walks a 20-bit address across an external memory and reads the bytes back. In both parallel modes the bus starts 8 bits wide and can be widened to 16 bits part-way through a download by setting a control bit.

Every accepted unit of data leaves on a registered output with a valid strobe, one cycle after it was sampled. The block counts delivered bytes against a programmed total, ends the download with a one-cycle done pulse, and holds an active-low status output low for as long as it is in reset or downloading. In mode 1 a chip select gates the start of a download, and releasing that select mid-download aborts it with a one-cycle error pulse.

Top module: `cfgl_front`

## Requirements
- R1: `status_n` is 0 while `rst_n` is low, while the block is in its reset state and for the whole download; in every other state it follows `user_level`.
- R2: A download begins when `start` is sampled high in the idle state with `mode_sel` equal to 0, 2, 6 or 7; with `mode_sel` equal to 1 it also needs `sel0_n` low; with `mode_sel` equal to 3, 4 or 5 `start` is ignored and `status_n` keeps following `user_level`.
- R3: In modes 0, 1 and 7 each cycle with `xfer_en` high shifts `din[0]` in, first bit as the most significant; every eighth bit produces a byte on `dout[7:0]` with `dout[15:8]` zero; `din[15:1]` have no effect.
- R4: In modes 2 and 6 with the narrow bus, each cycle with `xfer_en` high delivers `din[7:0]` on `dout[7:0]` with `dout[15:8]` zero and `dout_wide` low; `din[15:8]` have no effect.
- R5: A `wide_set` pulse during a download in mode 2 or 6 makes every later transfer of that download carry all of `din[15:0]` with `dout_wide` high and count as two bytes; in serial modes `wide_set` is ignored, and each new download starts narrow.
- R6: `addr_oe` is 1 only during a download in mode 6; whenever it is 0, `addr_out` is 0 (pad released).
- R7: In mode 6 `addr_out` is 0 at the start of every download and rises by one after each transfer, narrow or wide.
- R8: When the bytes delivered reach or pass `byte_total`, `load_done` is high for exactly one cycle, the same cycle as the final `dout_valid`, and `status_n` then follows `user_level`.
- R9: In mode 1, `sel0_n` sampled high during a download aborts it: in the next cycle `load_abort` is high for one cycle, no data is delivered, `status_n` follows `user_level`, and a later download starts from an empty shift register.
- R10: `man_rst` high sends the block from any state to its reset state in the next cycle; the cycle after it is sampled low the block is idle.
- R11: `dout_valid` rises in the cycle after the edge that sampled the completing transfer and stays high for one cycle per unit delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| man_rst | input | 1 | Manual reset request, synchronous, active high |
| mode_sel | input | 3 | Transfer mode: 0, 1, 7 serial; 2 peripheral; 6 master |
| start | input | 1 | Request to begin a download |
| sel0_n | input | 1 | Mode-1 chip select, active low |
| wide_set | input | 1 | Control bit write that widens the bus to 16 bits |
| xfer_en | input | 1 | A bit or unit is present on `din` this cycle |
| din | input | 16 | Configuration data input |
| byte_total | input | 16 | Bytes that make up a complete download |
| user_level | input | 1 | Level the status output takes when released |
| status_n | output | 1 | Active-low reset/download status |
| addr_out | output | 20 | External memory address (mode 6) |
| addr_oe | output | 1 | Address output enable |
| dout | output | 16 | Delivered configuration byte or word |
| dout_valid | output | 1 | `dout` carries a new unit |
| dout_wide | output | 1 | The delivered unit is a 16-bit word |
| load_done | output | 1 | One-cycle pulse at download completion |
| load_abort | output | 1 | One-cycle pulse when a mode-1 download is aborted |

## Verification
The hardest situation to reach is a chip-select release that lands between two byte boundaries of a mode-1 serial stream, followed by a fresh download: only then does a stale bit count show up as a misaligned byte. The bench delivers one full byte, shifts three bits of a second one, lifts `sel0_n`, and then restarts with a new pattern whose first byte must come out whole. The mid-download switch from 8 to 16 bits is reached the same way, by pulsing `wide_set` between narrow transfers in both parallel modes and checking that the byte count and the address step follow.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   typedef enum logic [2:0] {
      ST_RESET = 3'd0,
      ST_IDLE  = 3'd1,
      ST_LOAD  = 3'd2,
      ST_ABORT = 3'd3,
      ST_DONE  = 3'd4
   } cfgl_state_e;

   localparam logic [2:0] MODE_SER0   = 3'd0;
   localparam logic [2:0] MODE_SEL1   = 3'd1;
   localparam logic [2:0] MODE_PERIPH = 3'd2;
   localparam logic [2:0] MODE_MASTER = 3'd6;
   localparam logic [2:0] MODE_SER7   = 3'd7;

   function automatic logic is_serial(input logic [2:0] m);
      return (m == MODE_SER0) || (m == MODE_SEL1) || (m == MODE_SER7);
   endfunction

   function automatic logic is_parallel(input logic [2:0] m);
      return (m == MODE_PERIPH) || (m == MODE_MASTER);
   endfunction

   function automatic logic is_legal(input logic [2:0] m);
      return is_serial(m) || is_parallel(m);
   endfunction

endpackage

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
   import cfgl_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             man_rst,
   input  logic [2:0]       mode_sel,
   input  logic             start,
   input  logic             sel0_n,
   input  logic             beat,
   input  logic             beat_two,
   input  logic [CNT_W-1:0] byte_total,
   input  logic             user_level,
   output logic [2:0]       mode_q,
   output logic             loading,
   output logic             accept,
   output logic             clr,
   output logic             status_n,
   output logic             load_done,
   output logic             load_abort
);

   localparam int SUM_W = CNT_W + 1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("cfgl_ctrl: CNT_W must be at least 2");
      end
   endgenerate

   cfgl_state_e      st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum;
   logic             go, kill, reached;

   assign go      = start && is_legal(mode_sel) &&
                    ((mode_sel != MODE_SEL1) || !sel0_n);
   assign kill    = (mode_q == MODE_SEL1) && sel0_n;
   assign loading = (st_q == ST_LOAD);
   assign accept  = loading && !kill;
   assign clr     = (st_q == ST_IDLE) && go && !man_rst;
   assign sum     = {1'b0, cnt_q} + SUM_W'(beat_two ? 2 : 1);
   assign reached = sum >= {1'b0, byte_total};

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RESET: st_d = ST_IDLE;
         ST_IDLE:  if (go) st_d = ST_LOAD;
         ST_LOAD: begin
            if (kill)                 st_d = ST_ABORT;
            else if (beat && reached) st_d = ST_DONE;
         end
         ST_ABORT: st_d = ST_IDLE;
         ST_DONE:  st_d = ST_IDLE;
         default:  st_d = ST_RESET;
      endcase
      if (man_rst) st_d = ST_RESET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RESET;
         mode_q <= MODE_SER0;
         cnt_q  <= '0;
      end else begin
         st_q <= st_d;
         if (clr) begin
            mode_q <= mode_sel;
            cnt_q  <= '0;
         end else if (beat) begin
            cnt_q <= sum[CNT_W-1:0];
         end
      end
   end

   assign status_n   = ((st_q == ST_RESET) || (st_q == ST_LOAD)) ? 1'b0 : user_level;
   assign load_done  = (st_q == ST_DONE);
   assign load_abort = (st_q == ST_ABORT);

   assert_reset_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      man_rst |=> !status_n);
   assert_done_pulse_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> !load_done);
   assert_abort_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      load_abort |=> !load_abort);
   assert_abort_cause_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      load_abort |-> ($past(sel0_n) && ($past(mode_q) == MODE_SEL1)));

endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
   parameter int NARROW_W  = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                en,
   input  logic                bit_i,
   output logic                byte_rdy,
   output logic [NARROW_W-1:0] byte_val
);

   localparam int BC_W = $clog2(NARROW_W);

   generate
      if ((1 << BC_W) != NARROW_W) begin : g_bad_w
         $error("cfgl_shift: NARROW_W must be a power of two");
      end
   endgenerate

   logic [NARROW_W-1:0] sh_q;
   logic [BC_W-1:0]     bc_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign byte_val = {sh_q[NARROW_W-2:0], bit_i};
      end else begin : g_lsb
         assign byte_val = {bit_i, sh_q[NARROW_W-1:1]};
      end
   endgenerate

   assign byte_rdy = en && (bc_q == BC_W'(NARROW_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         bc_q <= '0;
      end else if (clr) begin
         sh_q <= '0;
         bc_q <= '0;
      end else if (en) begin
         sh_q <= byte_val;
         bc_q <= bc_q + 1'b1;
      end
   end

   assert_wrap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (byte_rdy && !clr) |=> (bc_q == '0));

endmodule

// File: rtl/cfgl_addr.sv
module cfgl_addr #(
   parameter int ADDR_W    = 20,
   parameter bit MASTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic              drive,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_oe
);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
         $error("cfgl_addr: ADDR_W out of range");
      end
   endgenerate

   generate
      if (MASTER_EN) begin : g_master
         logic [ADDR_W-1:0] addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   addr_q <= '0;
            else if (clr) addr_q <= '0;
            else if (inc) addr_q <= addr_q + 1'b1;
         end
         assign addr_oe  = drive;
         assign addr_out = drive ? addr_q : '0;

         assert_step_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !clr) |=> (addr_q == $past(addr_q) + 1'b1));
         assert_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (addr_q == '0));
      end else begin : g_no_master
         logic unused_in;
         assign unused_in = ^{clk, rst_n, clr, inc, drive};
         assign addr_oe   = 1'b0;
         assign addr_out  = '0;
      end
   endgenerate

endmodule

// File: rtl/cfgl_front.sv
module cfgl_front
   import cfgl_pkg::*;
#(
   parameter int NARROW_W  = 8,
   parameter int WIDE_W    = 16,
   parameter int ADDR_W    = 20,
   parameter int CNT_W     = 16,
   parameter bit MASTER_EN = 1'b1,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              man_rst,
   input  logic [2:0]        mode_sel,
   input  logic              start,
   input  logic              sel0_n,
   input  logic              wide_set,
   input  logic              xfer_en,
   input  logic [WIDE_W-1:0] din,
   input  logic [CNT_W-1:0]  byte_total,
   input  logic              user_level,
   output logic              status_n,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_oe,
   output logic [WIDE_W-1:0] dout,
   output logic              dout_valid,
   output logic              dout_wide,
   output logic              load_done,
   output logic              load_abort
);

   localparam int UPPER_W = WIDE_W - NARROW_W;

   generate
      if (WIDE_W != 2 * NARROW_W) begin : g_bad_wide
         $error("cfgl_front: WIDE_W must be twice NARROW_W");
      end
   endgenerate

   logic [2:0]          mode_q;
   logic                loading, accept, clr;
   logic                ser, ser_en, par_take;
   logic                ser_rdy, beat, beat_two;
   logic [NARROW_W-1:0] ser_byte;
   logic                wide_q;
   logic [WIDE_W-1:0]   unit_d;

   assign ser      = is_serial(mode_q);
   assign ser_en   = accept && xfer_en && ser;
   assign par_take = accept && xfer_en && !ser;
   assign beat     = ser ? ser_rdy : par_take;
   assign beat_two = par_take && wide_q;

   cfgl_ctrl #(.CNT_W(CNT_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .man_rst    (man_rst),
      .mode_sel   (mode_sel),
      .start      (start),
      .sel0_n     (sel0_n),
      .beat       (beat),
      .beat_two   (beat_two),
      .byte_total (byte_total),
      .user_level (user_level),
      .mode_q     (mode_q),
      .loading    (loading),
      .accept     (accept),
      .clr        (clr),
      .status_n   (status_n),
      .load_done  (load_done),
      .load_abort (load_abort)
   );

   cfgl_shift #(.NARROW_W(NARROW_W), .MSB_FIRST(MSB_FIRST)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .en       (ser_en),
      .bit_i    (din[0]),
      .byte_rdy (ser_rdy),
      .byte_val (ser_byte)
   );

   cfgl_addr #(.ADDR_W(ADDR_W), .MASTER_EN(MASTER_EN)) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .inc      (par_take && (mode_q == MODE_MASTER)),
      .drive    (loading && (mode_q == MODE_MASTER)),
      .addr_out (addr_out),
      .addr_oe  (addr_oe)
   );

   always_comb begin
      if (ser)         unit_d = {{UPPER_W{1'b0}}, ser_byte};
      else if (wide_q) unit_d = din;
      else             unit_d = {{UPPER_W{1'b0}}, din[NARROW_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q     <= 1'b0;
         dout       <= '0;
         dout_valid <= 1'b0;
         dout_wide  <= 1'b0;
      end else begin
         if (clr)                            wide_q <= 1'b0;
         else if (accept && !ser && wide_set) wide_q <= 1'b1;
         dout_valid <= beat;
         dout_wide  <= beat_two;
         if (beat) dout <= unit_d;
      end
   end

   assert_narrow_upper_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && !dout_wide) |-> (dout[WIDE_W-1:NARROW_W] == '0));
   assert_serial_narrow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && is_serial(mode_q)) |-> !dout_wide);
   assert_valid_cause_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> $past(xfer_en));

endmodule

// File: tb/test_cfgl_front.sv
module test_cfgl_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        man_rst = 1'b0;
   logic [2:0]  mode_sel = 3'd0;
   logic        start = 1'b0;
   logic        sel0_n = 1'b1;
   logic        wide_set = 1'b0;
   logic        xfer_en = 1'b0;
   logic [15:0] din = 16'h0;
   logic [15:0] byte_total = 16'd1;
   logic        user_level = 1'b1;
   logic        status_n;
   logic [19:0] addr_out;
   logic        addr_oe;
   logic [15:0] dout;
   logic        dout_valid;
   logic        dout_wide;
   logic        load_done;
   logic        load_abort;

   int checks = 0;
   int errs   = 0;

   always #5 clk = ~clk;

   cfgl_front i_cfgl_front (
      .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .mode_sel(mode_sel),
      .start(start), .sel0_n(sel0_n), .wide_set(wide_set), .xfer_en(xfer_en),
      .din(din), .byte_total(byte_total), .user_level(user_level),
      .status_n(status_n), .addr_out(addr_out), .addr_oe(addr_oe),
      .dout(dout), .dout_valid(dout_valid), .dout_wide(dout_wide),
      .load_done(load_done), .load_abort(load_abort)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic begin_load(input logic [2:0] m, input int total);
      @(negedge clk);
      mode_sel = m; byte_total = 16'(total); start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic beat_in(input logic [15:0] d);
      @(negedge clk);
      din = d; xfer_en = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic quiet();
      @(negedge clk);
      xfer_en = 1'b0; wide_set = 1'b0;
      @(posedge clk); #1;
   endtask

   function automatic logic [7:0] pat(input int m, input int k);
      return 8'((k * 37 + m * 11 + 5) & 8'hFF);
   endfunction

   // one serial byte; noisy upper lines must be ignored (R3)
   task automatic ser_byte(input logic [7:0] v, input logic last);
      for (int i = 7; i >= 0; i--) begin
         beat_in({15'h6D2B ^ 15'(i), v[i]});
         if (i == 4) chk("R3 no strobe mid-byte", 32'(dout_valid), 32'd0);
      end
      chk("R11 serial strobe", 32'(dout_valid), 32'd1);
      chk("R3 serial byte", 32'(dout), 32'(v));
      chk("R8 done timing", 32'(load_done), 32'(last));
   endtask

   task automatic serial_run(input logic [2:0] m, input int n);
      begin_load(m, n);
      chk("R1 low in load", 32'(status_n), 32'd0);
      chk("R6 no addr serial", 32'({addr_oe, addr_out}), 32'd0);
      if (m == 3'd0) begin
         @(negedge clk); wide_set = 1'b1;
         @(posedge clk); #1;
         @(negedge clk); wide_set = 1'b0;
      end
      for (int k = 0; k < n; k++) ser_byte(pat(m, k), k == n - 1);
      if (m == 3'd0) chk("R5 serial ignores wide", 32'(dout_wide), 32'd0);
      quiet();
      chk("R8 released", 32'(status_n), 32'(user_level));
      chk("R8 done one cycle", 32'(load_done), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 low in power-on reset", 32'(status_n), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      @(posedge clk); #1;
      chk("R1 idle follows user", 32'(status_n), 32'd1);
      @(negedge clk); user_level = 1'b0;
      #1 chk("R1 idle follows user low", 32'(status_n), 32'd0);
      @(negedge clk); user_level = 1'b1;

      // serial modes
      serial_run(3'd0, 3);
      serial_run(3'd7, 2);
      @(negedge clk); sel0_n = 1'b0;
      serial_run(3'd1, 2);

      // R2: mode 1 start without select is ignored
      @(negedge clk); sel0_n = 1'b1;
      begin_load(3'd1, 1);
      @(posedge clk); #1;
      chk("R2 mode1 needs select", 32'(status_n), 32'd1);

      // R2: illegal modes never start
      for (int m = 3; m <= 5; m++) begin
         begin_load(3'(m), 1);
         beat_in(16'h00FF);
         quiet();
         chk("R2 illegal mode ignored", 32'({status_n, dout_valid}), 32'h2);
      end

      // R4/R5/R6: peripheral mode, narrow then wide
      begin_load(3'd2, 8);
      for (int k = 0; k < 2; k++) begin
         beat_in({8'hA5, pat(2, k)});
         chk("R4 narrow byte", 32'({dout_wide, dout}), 32'(pat(2, k)));
         chk("R6 no addr in mode 2", 32'(addr_oe), 32'd0);
      end
      @(negedge clk); xfer_en = 1'b0; wide_set = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); wide_set = 1'b0;
      for (int k = 0; k < 3; k++) begin
         beat_in(16'(k * 16'h1357 + 16'h2468));
         chk("R5 wide word", 32'({dout_wide, dout}), 32'h10000 | 32'(k * 16'h1357 + 16'h2468));
         chk("R8 done after wide count", 32'(load_done), 32'(k == 2));
      end
      quiet();

      // R5: next download starts narrow again; R7 master addressing
      begin_load(3'd6, 5);
      for (int k = 0; k < 5; k++) begin
         chk("R7 address", 32'(addr_out), 32'(k));
         chk("R6 oe in mode 6", 32'(addr_oe), 32'd1);
         beat_in({8'hFF, pat(6, k)});
         chk("R5 narrow after restart", 32'({dout_wide, dout}), 32'(pat(6, k)));
      end
      chk("R8 master done", 32'(load_done), 32'd1);
      quiet();
      chk("R6 released after load", 32'({addr_oe, addr_out}), 32'd0);

      // R7: master wide, address steps by one per word
      begin_load(3'd6, 6);
      beat_in(16'h1111);
      @(negedge clk); xfer_en = 1'b0; wide_set = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); wide_set = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R7 wide address", 32'(addr_out), 32'(k + 1));
         beat_in(16'hC000 + 16'(k));
      end
      chk("R8 odd total reached", 32'(load_done), 32'd1);
      quiet();

      // R9: abort in mode 1 between byte boundaries
      @(negedge clk); sel0_n = 1'b0;
      begin_load(3'd1, 4);
      ser_byte(8'h3C, 1'b0);
      for (int i = 0; i < 3; i++) beat_in(16'h0001);
      @(negedge clk); sel0_n = 1'b1; din = 16'h0001;
      @(posedge clk); #1;
      chk("R9 abort pulse", 32'(load_abort), 32'd1);
      chk("R9 no data on abort", 32'(dout_valid), 32'd0);
      chk("R9 status released", 32'(status_n), 32'(user_level));
      quiet();
      chk("R9 abort one cycle", 32'(load_abort), 32'd0);
      @(negedge clk); sel0_n = 1'b0;
      serial_run(3'd1, 1);

      // R10: manual reset mid-download
      begin_load(3'd2, 10);
      beat_in(16'h0042);
      @(negedge clk); xfer_en = 1'b0; man_rst = 1'b1;
      @(posedge clk); #1;
      chk("R10 reset state", 32'(status_n), 32'd0);
      @(negedge clk); man_rst = 1'b0;
      @(posedge clk); #1;
      chk("R10 idle after release", 32'(status_n), 32'(user_level));
      beat_in(16'h0042);
      chk("R10 no delivery when idle", 32'(dout_valid), 32'd0);
      quiet();

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

endmodule